// File: doc/BRIEF.md
# Mixed-Length Instruction Decode and Execute Stage

This block decodes and executes one instruction per clock for a small 32-bit RISC core. Instructions are either 24 or 16 bits long. A single 4-bit major opcode sits in the four least significant bits of every instruction word, and it selects both the format and the length. The block holds the program counter and a 16-entry, 32-bit register file. Each cycle it reads the instruction presented at `insn` and produces combinational results: the writeback enable, destination and value, the next PC, the instruction length and an illegal-instruction flag. On the rising clock edge it commits the writeback and loads the PC with the next PC.

A 16-bit instruction occupies `insn[15:0]`. Bits 23:16 are then ignored. The supported operations are a three-register add in both lengths, an add of a sign-extended 16-bit constant, a signed less-than compare branch, a branch on register equal to zero, and a PC-relative call that leaves its return address in register 0.

Top module: `mixlen_decode`

## Requirements
- R1: Major opcode `op = insn[3:0]`. When `op[3]` is 1 the instruction is 16 bits long and `insn_len` reads 2. Otherwise it is 24 bits long and `insn_len` reads 3.
- R2: For any instruction that is not a taken branch and not a call, `next_pc` equals `pc_o + insn_len`.
- R3: With `op` = 0, `insn[23:20]` = 0 and `insn[19:16]` = 0, the block writes `reg[insn[11:8]] + reg[insn[7:4]]` into register `insn[15:12]`.
- R4: With `op` = 8 (16-bit), the block writes `reg[insn[11:8]] + reg[insn[7:4]]` into register `insn[15:12]`. Bits 23:16 have no effect.
- R5: With `op` = 3, the block writes `reg[insn[7:4]]` plus the sign-extended `insn[23:8]` back into register `insn[7:4]`.
- R6: With `op` = 1, the branch is taken when `reg[insn[11:8]]` is less than `reg[insn[7:4]]` as signed numbers. A taken branch sets `next_pc = pc_o` plus the sign-extended `insn[23:16]`. This operation writes no register.
- R7: With `op` = 2, the branch is taken when `reg[insn[11:8]]` is zero. A taken branch sets `next_pc = pc_o` plus the sign-extended `insn[23:12]`. This operation writes no register.
- R8: With `op` = 4, `next_pc = pc_o` plus the sign-extended `insn[23:6]`. The value `pc_o + 3` is written into register 0. Bits 5:4 are ignored.
- R9: Every other opcode raises `illegal`, and so does `op` = 0 with a nonzero `insn[23:16]`. An illegal instruction writes no register and advances the PC by `insn_len`.
- R10: `rst_n` is an active-low synchronous reset. It clears the PC and all registers. Out of reset, the PC loads `next_pc` on every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn | input | 24 | Fetched instruction word; 16-bit forms in bits 15:0 |
| pc_o | output | 32 | Current program counter |
| next_pc | output | 32 | PC after this instruction |
| insn_len | output | 2 | Instruction length in bytes (2 or 3) |
| wb_en | output | 1 | Register write enable |
| wb_addr | output | 4 | Destination register |
| wb_data | output | 32 | Value written back |
| illegal | output | 1 | Unsupported encoding |

## Verification
The register file can only be observed through the results of later instructions. For that reason the stimulus is a single dependent program. Immediate adds load known values, including a negative one, so that the signed compare gives the opposite result from an unsigned one. A later add reads register 0 right after an illegal instruction whose destination field names register 0. This proves that the illegal instruction's write was blocked and that the call's return address survived. Backward branch and call offsets exercise sign extension of the 12- and 18-bit fields.

// File: rtl/mixlen_decode.sv
module mixlen_decode #(
  parameter int XLEN = 32,
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [23:0]     insn,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc,
  output logic [1:0]      insn_len,
  output logic            wb_en,
  output logic [3:0]      wb_addr,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal
);
  localparam logic [3:0] OP_RRR  = 4'h0;
  localparam logic [3:0] OP_BLT  = 4'h1;
  localparam logic [3:0] OP_BEQZ = 4'h2;
  localparam logic [3:0] OP_ADDI = 4'h3;
  localparam logic [3:0] OP_CALL = 4'h4;
  localparam logic [3:0] OP_NADD = 4'h8;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] pc_q;

  logic [3:0] op, ft, fs, fr;
  logic [XLEN-1:0] rs, rt, seq_pc;
  logic [XLEN-1:0] off8, off12, off16, off18;

  assign op = insn[3:0];
  assign ft = insn[7:4];
  assign fs = insn[11:8];
  assign fr = insn[15:12];

  assign rs = regs[fs];
  assign rt = regs[ft];

  assign off8  = {{(XLEN-8){insn[23]}},  insn[23:16]};
  assign off12 = {{(XLEN-12){insn[23]}}, insn[23:12]};
  assign off16 = {{(XLEN-16){insn[23]}}, insn[23:8]};
  assign off18 = {{(XLEN-18){insn[23]}}, insn[23:6]};

  assign insn_len = op[3] ? 2'd2 : 2'd3;
  assign seq_pc   = pc_q + XLEN'(insn_len);
  assign pc_o     = pc_q;

  always_comb begin
    next_pc = seq_pc;
    wb_en   = 1'b0;
    wb_addr = fr;
    wb_data = rs + rt;
    illegal = 1'b0;
    case (op)
      OP_RRR: begin
        if (insn[23:16] == 8'h00) wb_en = 1'b1;
        else illegal = 1'b1;
      end
      OP_NADD: wb_en = 1'b1;
      OP_ADDI: begin
        wb_en   = 1'b1;
        wb_addr = ft;
        wb_data = rt + off16;
      end
      OP_BLT:  if ($signed(rs) < $signed(rt)) next_pc = pc_q + off8;
      OP_BEQZ: if (rs == '0) next_pc = pc_q + off12;
      OP_CALL: begin
        next_pc = pc_q + off18;
        wb_en   = 1'b1;
        wb_addr = 4'd0;
        wb_data = pc_q + XLEN'(3);
      end
      default: illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      pc_q <= next_pc;
      if (wb_en) regs[wb_addr] <= wb_data;
    end
  end
endmodule

// File: rtl/mixlen_decode_sva.sv
module mixlen_decode_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [23:0]     insn,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] next_pc,
  input logic [1:0]      insn_len,
  input logic            wb_en,
  input logic [3:0]      wb_addr,
  input logic [XLEN-1:0] wb_data,
  input logic            illegal
);
  assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    insn_len == (insn[3] ? 2'd2 : 2'd3));

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[3:0] == 4'h0 || insn[3:0] == 4'h3 || insn[3:0] == 4'h8)
    |-> next_pc == pc_o + XLEN'(insn_len));

  assert_call_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[3:0] == 4'h4) |-> (wb_en && wb_addr == 4'd0 && wb_data == pc_o + XLEN'(3)));

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);

  assert_pc_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pc_o == $past(next_pc));
endmodule

bind mixlen_decode mixlen_decode_sva #(.XLEN(XLEN)) i_sva (
  .clk(clk), .rst_n(rst_n), .insn(insn), .pc_o(pc_o), .next_pc(next_pc),
  .insn_len(insn_len), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
  .illegal(illegal)
);

// File: tb/test_mixlen_decode.sv
module test_mixlen_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] insn = 24'h0;
  logic [31:0] pc_o, next_pc, wb_data;
  logic [1:0]  insn_len;
  logic        wb_en, illegal;
  logic [3:0]  wb_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mixlen_decode i_mixlen_decode (
    .clk(clk), .rst_n(rst_n), .insn(insn), .pc_o(pc_o), .next_pc(next_pc),
    .insn_len(insn_len), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .illegal(illegal)
  );

  // {insn, next_pc, wb_en, wb_addr, wb_data, len, illegal}
  localparam int NV = 14;
  localparam logic [95:0] VEC [NV] = '{
    {24'h000513, 32'h00000003, 1'b1, 4'h1, 32'h00000005, 2'd3, 1'b0}, // R5 r1=5
    {24'hFFFE23, 32'h00000006, 1'b1, 4'h2, 32'hFFFFFFFE, 2'd3, 1'b0}, // R5 r2=-2
    {24'h003120, 32'h00000009, 1'b1, 4'h3, 32'h00000003, 2'd3, 1'b0}, // R3
    {24'hAB4318, 32'h0000000B, 1'b1, 4'h4, 32'h00000008, 2'd2, 1'b0}, // R4 R1
    {24'h100211, 32'h0000001B, 1'b0, 4'h0, 32'h00000000, 2'd3, 1'b0}, // R6 taken
    {24'h100121, 32'h0000001E, 1'b0, 4'h0, 32'h00000000, 2'd3, 1'b0}, // R6 signed not taken
    {24'hFF8502, 32'h00000016, 1'b0, 4'h0, 32'h00000000, 2'd3, 1'b0}, // R7 backward
    {24'h100102, 32'h00000019, 1'b0, 4'h0, 32'h00000000, 2'd3, 1'b0}, // R7 not taken R2
    {24'h001004, 32'h00000059, 1'b1, 4'h0, 32'h0000001C, 2'd3, 1'b0}, // R8 forward
    {24'hFFFC04, 32'h00000049, 1'b1, 4'h0, 32'h0000005C, 2'd3, 1'b0}, // R8 backward
    {24'h000005, 32'h0000004C, 1'b0, 4'h0, 32'h00000000, 2'd3, 1'b1}, // R9 wide
    {24'h00000C, 32'h0000004E, 1'b0, 4'h0, 32'h00000000, 2'd2, 1'b1}, // R9 narrow
    {24'h100120, 32'h00000051, 1'b0, 4'h0, 32'h00000000, 2'd3, 1'b1}, // R9 op2!=0
    {24'h005040, 32'h00000054, 1'b1, 4'h5, 32'h00000064, 2'd3, 1'b0}  // R9 r0 kept
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL R10 watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset pc", pc_o, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      insn = VEC[i][95:72];
      #2;
      chk($sformatf("R2/R6/R7/R8 next_pc v%0d", i), next_pc, VEC[i][71:40]);
      chk($sformatf("R9 wb_en v%0d", i), 32'(wb_en), 32'(VEC[i][39]));
      chk($sformatf("R1 insn_len v%0d", i), 32'(insn_len), 32'(VEC[i][2:1]));
      chk($sformatf("R9 illegal v%0d", i), 32'(illegal), 32'(VEC[i][0]));
      if (VEC[i][39]) begin
        chk($sformatf("R3/R4/R5/R8 wb_addr v%0d", i), 32'(wb_addr), 32'(VEC[i][38:35]));
        chk($sformatf("R3/R4/R5/R8 wb_data v%0d", i), wb_data, VEC[i][34:3]);
      end
      @(negedge clk);
      chk($sformatf("R10 pc load v%0d", i), pc_o, VEC[i][71:40]);
    end

    // R10: reset in the middle of a run clears the PC and the registers
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 pc after reset", pc_o, 32'h0);
    rst_n = 1'b1;
    insn = 24'h006120; // r6 = r1 + r2
    #2;
    chk("R10 regs cleared", wb_data, 32'h0);
    chk("R2 next after reset", next_pc, 32'h3);
    @(negedge clk);

    // R4: narrow add with garbage upper bits, r7 = r0 + r0 = 0
    insn = 24'hFF7008;
    #2;
    chk("R4 narrow upper ignored", wb_data, 32'h0);
    chk("R1 narrow next", next_pc, 32'h5);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule